// File: doc/BRIEF.md
# Wait-Pin Edge Interrupt Controller

This block is the interrupt unit of an external-memory controller. It gathers two fixed event pulses from the flash engine and the edges seen on a configurable number of asynchronous wait inputs. Each source sets its own bit in a sticky status register. An enable register picks which pending bits may raise the single interrupt line. Software acknowledges a bit by writing a one to it.

Each wait input passes through a two-stage synchroniser and then an edge detector. The detector looks for one direction only: rising or falling, chosen per pin by a polarity bit. The flash event sources have no polarity control. The status and enable layouts leave a gap: the flash events take bits 0 and 1, bits 2 to 7 are reserved, and wait pin N sits at bit 8+N. A plain synchronous register port reads and writes the three registers.

Top module: `wait_edge_irq_ctrl`

## Requirements
- R1: Register address 0 is status. Status bit 0 is set by a cycle-long pulse on `nand_fifo_evt_i`, and bit 1 by one on `nand_tc_evt_i`. The bit is set at the clock edge that samples the pulse.
- R2: Bits 2 to 7 of the status register (address 0) and of the enable register (address 1) always read as zero and ignore writes. Bits above 8+NUM_WAIT-1 also read as zero.
- R3: Wait pin N reports at status bit 8+N. A change on the pin before clock edge k sets the status bit at edge k+2 (two synchroniser stages and one edge stage).
- R4: Config register (address 2) bit 8+N selects the edge polarity of wait pin N: 0 detects rising edges, 1 detects falling edges. An edge in the other direction sets nothing.
- R5: Config bits 0 to 7 read as zero, ignore writes and have no effect on the flash event bits.
- R6: Writing to address 0 clears every status bit written as 1. A status bit written as 0 keeps its value.
- R7: A source sets its status bit whatever the enable bit holds, so a masked event stays pending until it is cleared.
- R8: `irq_o` is a register that holds the OR of (status AND enable) from the previous cycle.
- R9: When a source event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R10: After reset, status, enable and config read as zero and `irq_o` is low. Address 3 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nand_fifo_evt_i | input | 1 | Flash FIFO event pulse, synchronous |
| nand_tc_evt_i | input | 1 | Flash terminal-count pulse, synchronous |
| wait_pin_i | input | NUM_WAIT | Asynchronous wait inputs |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write when high, with reg_req_i |
| reg_addr_i | input | 2 | Register select: 0 status, 1 enable, 2 config |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to bring about is an edge that comes out of the synchroniser in exactly the cycle a write-one-to-clear targets the same bit. The pin must change two cycles before the write, so the clear has to be lined up with the pipeline depth. Directed tests set up that alignment for both a flash event and a wait pin. A long random phase then toggles pins, flips polarities and issues clears against a cycle-accurate bench model, so many further collisions occur, some of them with the polarity changing mid-pipeline.

// File: rtl/wirq_pkg.sv
`timescale 1ns/1ps
package wirq_pkg;
  localparam int unsigned NandBits = 2;
  localparam int unsigned WaitBase = 8;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_EN   = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wirq_pin_edge.sv
`timescale 1ns/1ps
module wirq_pin_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  // [0],[1] synchroniser, [2] previous synchronised value
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], pin_i};
  end

  logic rise, fall;
  assign rise   = sh_q[1] & ~sh_q[2];
  assign fall   = ~sh_q[1] & sh_q[2];
  assign edge_o = fall_sel_i ? fall : rise;
endmodule

// File: rtl/wirq_regs.sv
`timescale 1ns/1ps
module wirq_regs
  import wirq_pkg::*;
#(
  parameter int unsigned NUM_WAIT = 4,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned StatW   = WaitBase + NUM_WAIT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [1:0]          addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [StatW-1:0]    evt_i,
  output logic [StatW-1:0]    stat_o,
  output logic [StatW-1:0]    en_o,
  output logic [NUM_WAIT-1:0] pol_o,
  output logic [DATA_W-1:0]   rdata_o
);
  logic [StatW-1:0] valid_mask;
  for (genvar i = 0; i < StatW; i++) begin : g_mask
    assign valid_mask[i] = (i < NandBits) || (i >= WaitBase);
  end

  logic [StatW-1:0]    stat_q, en_q;
  logic [NUM_WAIT-1:0] pol_q;
  logic [StatW-1:0]    wr_bits;
  logic                wr_stat, wr_en, wr_cfg;

  assign wr_bits = wdata_i[StatW-1:0];
  assign wr_stat = req_i && we_i && (reg_sel_e'(addr_i) == SEL_STAT);
  assign wr_en   = req_i && we_i && (reg_sel_e'(addr_i) == SEL_EN);
  assign wr_cfg  = req_i && we_i && (reg_sel_e'(addr_i) == SEL_CFG);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata_i;

  logic [StatW-1:0] clr, stat_d;
  assign clr    = wr_stat ? (wr_bits & valid_mask) : '0;
  // a new event wins over a clear of the same bit
  assign stat_d = ((stat_q & ~clr) | evt_i) & valid_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
      pol_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr_en)  en_q  <= wr_bits & valid_mask;
      if (wr_cfg) pol_q <= wr_bits[StatW-1:WaitBase];
    end
  end

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      SEL_STAT: rdata_o = DATA_W'(stat_q);
      SEL_EN:   rdata_o = DATA_W'(en_q);
      SEL_CFG:  rdata_o = DATA_W'({pol_q, {WaitBase{1'b0}}});
      default:  rdata_o = '0;
    endcase
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign pol_o  = pol_q;
endmodule

// File: rtl/wirq_irq_out.sv
`timescale 1ns/1ps
module wirq_irq_out #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] en_i,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(stat_i & en_i);
  end
endmodule

// File: rtl/wait_edge_irq_ctrl.sv
`timescale 1ns/1ps
module wait_edge_irq_ctrl
  import wirq_pkg::*;
#(
  parameter int unsigned NUM_WAIT = 4,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                nand_fifo_evt_i,
  input  logic                nand_tc_evt_i,
  input  logic [NUM_WAIT-1:0] wait_pin_i,
  input  logic                reg_req_i,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_o
);
  localparam int unsigned StatW = WaitBase + NUM_WAIT;

  logic [NUM_WAIT-1:0] pin_edge, pol;
  logic [StatW-1:0]    evt, stat_q, en_q;

  for (genvar n = 0; n < NUM_WAIT; n++) begin : g_pin
    wirq_pin_edge u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (wait_pin_i[n]),
      .fall_sel_i (pol[n]),
      .edge_o     (pin_edge[n])
    );
  end

  assign evt = {pin_edge, {(WaitBase-NandBits){1'b0}}, nand_tc_evt_i, nand_fifo_evt_i};

  wirq_regs #(.NUM_WAIT(NUM_WAIT), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (reg_req_i),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .evt_i   (evt),
    .stat_o  (stat_q),
    .en_o    (en_q),
    .pol_o   (pol),
    .rdata_o (reg_rdata_o)
  );

  wirq_irq_out #(.W(StatW)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stat_i (stat_q),
    .en_i   (en_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/wirq_checker.sv
`timescale 1ns/1ps
module wirq_checker #(
  parameter int unsigned STAT_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] en_q
);
  logic [STAT_W-1:0] clr_req;
  assign clr_req = (reg_req_i && reg_we_i && reg_addr_i == 2'd0) ? reg_wdata_i[STAT_W-1:0] : '0;

  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[7:2] == 6'b0) && (en_q[7:2] == 6'b0));

  assert_irq_registered_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(stat_q & en_q))));

  // a status bit only falls when a write named it
  assert_sticky_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(stat_q) & ~stat_q) & ~$past(clr_req)) == '0));

  assert_irq_rise_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(stat_q & en_q)));
endmodule

bind wait_edge_irq_ctrl wirq_checker #(.STAT_W(StatW), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_o       (irq_o),
  .reg_req_i   (reg_req_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .stat_q      (stat_q),
  .en_q        (en_q)
);

// File: tb/tb_wait_edge_irq_ctrl.sv
`timescale 1ns/1ps
module tb_wait_edge_irq_ctrl;
  localparam int NW = 4;
  localparam int DW = 32;
  localparam int SW = 8 + NW;
  localparam logic [31:0] VALID = ((32'd1 << SW) - 1) & ~32'h0000_00FC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fifo_evt = 1'b0, tc_evt = 1'b0;
  logic [NW-1:0] pins = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wait_edge_irq_ctrl #(.NUM_WAIT(NW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .nand_fifo_evt_i(fifo_evt), .nand_tc_evt_i(tc_evt),
    .wait_pin_i(pins), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // requirement model
  logic [31:0]   m_stat = '0, m_en = '0;
  logic [NW-1:0] m_pol = '0, m_s1 = '0, m_s2 = '0, m_s3 = '0;
  logic          m_irq = 1'b0;

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return m_stat;
      2'd1: return m_en;
      2'd2: return {20'b0, m_pol, 8'b0};
      default: return 32'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle at negedge, advance the model, return at next negedge
  task automatic cyc(input logic f, input logic t, input logic [NW-1:0] w,
                     input logic rq, input logic wr, input logic [1:0] a, input logic [31:0] d);
    logic [31:0] evt, clr, nstat;
    logic [NW-1:0] edg;
    fifo_evt = f; tc_evt = t; pins = w; req = rq; we = wr; addr = a; wdata = d;
    edg   = (m_pol & ~m_s2 & m_s3) | (~m_pol & m_s2 & ~m_s3);
    evt   = {20'b0, edg, 6'b0, t, f};
    clr   = (rq && wr && a == 2'd0) ? (d & VALID) : 32'b0;
    nstat = ((m_stat & ~clr) | evt) & VALID;
    @(posedge clk);
    m_irq  = |(m_stat & m_en);
    m_stat = nstat;
    if (rq && wr && a == 2'd1) m_en = d & VALID;
    if (rq && wr && a == 2'd2) m_pol = d[SW-1:8];
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = w;
    @(negedge clk);
    fifo_evt = 1'b0; tc_evt = 1'b0; req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, pins, 1'b0, 1'b0, 2'd0, 32'b0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd("R10 status", 2'd0, 32'h0);
    rd("R10 enable", 2'd1, 32'h0);
    rd("R10 config", 2'd2, 32'h0);
    rd("R10 addr3", 2'd3, 32'h0);
    chk("R10 irq", {31'b0, irq}, 32'h0);

    // R2 reserved enable and status bits
    cyc(0, 0, '0, 1, 1, 2'd1, 32'hFFFF_FFFF);
    rd("R2 enable mask", 2'd1, 32'h0000_0F03);
    cyc(0, 0, '0, 1, 1, 2'd1, 32'h0);
    cyc(0, 0, '0, 1, 1, 2'd0, 32'hFFFF_FFFF);
    rd("R2 status stays zero", 2'd0, 32'h0);

    // R5 config low bits ignored, flash events unaffected; R1 bit positions
    cyc(0, 0, '0, 1, 1, 2'd2, 32'hFFFF_FFFF);
    rd("R5 config mask", 2'd2, 32'h0000_0F00);
    cyc(1, 0, '0, 0, 0, 2'd0, 32'h0);
    rd("R1 fifo bit0", 2'd0, 32'h0000_0001);
    cyc(0, 1, '0, 0, 0, 2'd0, 32'h0);
    rd("R1 tc bit1 R5", 2'd0, 32'h0000_0003);
    cyc(0, 0, '0, 1, 1, 2'd2, 32'h0);

    // R6 write 0 keeps, write 1 clears
    cyc(0, 0, '0, 1, 1, 2'd0, 32'h0000_0002);
    rd("R6 clear bit1 only", 2'd0, 32'h0000_0001);
    cyc(0, 0, '0, 1, 1, 2'd0, 32'h0);
    rd("R6 write zero no effect", 2'd0, 32'h0000_0001);
    cyc(0, 0, '0, 1, 1, 2'd0, 32'h0000_0001);
    rd("R6 clear bit0", 2'd0, 32'h0);

    // R3 latency: pin 0 rising, bit 8 appears at third edge
    cyc(0, 0, 4'b0001, 0, 0, 2'd0, 32'h0);
    rd("R3 after 1 edge", 2'd0, 32'h0);
    cyc(0, 0, 4'b0001, 0, 0, 2'd0, 32'h0);
    rd("R3 after 2 edges", 2'd0, 32'h0);
    cyc(0, 0, 4'b0001, 0, 0, 2'd0, 32'h0);
    rd("R3 after 3 edges bit8", 2'd0, 32'h0000_0100);
    cyc(0, 0, 4'b0000, 1, 1, 2'd0, 32'h0000_0100);
    idle(4);
    rd("R4 falling ignored on rising pin", 2'd0, 32'h0);

    // R4 pin 1 falling select
    cyc(0, 0, 4'b0000, 1, 1, 2'd2, 32'h0000_0200);
    cyc(0, 0, 4'b0010, 0, 0, 2'd0, 32'h0);
    idle(4);
    rd("R4 rise ignored when falling", 2'd0, 32'h0);
    cyc(0, 0, 4'b0000, 0, 0, 2'd0, 32'h0);
    idle(2);
    rd("R4 fall sets bit9", 2'd0, 32'h0000_0200);

    // R7 masked pending, R8 irq one cycle after enable
    chk("R7 masked no irq", {31'b0, irq}, 32'h0);
    cyc(0, 0, '0, 1, 1, 2'd1, 32'h0000_0200);
    chk("R8 irq not yet", {31'b0, irq}, 32'h0);
    idle(1);
    chk("R8 irq asserted", {31'b0, irq}, 32'h1);
    cyc(0, 0, '0, 1, 1, 2'd0, 32'h0000_0200);
    chk("R8 irq held one cycle", {31'b0, irq}, 32'h1);
    idle(1);
    chk("R8 irq dropped", {31'b0, irq}, 32'h0);

    // R9 collision: flash event and clear together
    cyc(1, 0, '0, 0, 0, 2'd0, 32'h0);
    cyc(1, 0, '0, 1, 1, 2'd0, 32'h0000_0001);
    rd("R9 fifo event wins", 2'd0, 32'h0000_0001);
    // R9 collision on a wait pin (pin 2 rising, edge at third cycle)
    cyc(0, 0, 4'b0100, 0, 0, 2'd0, 32'h0);
    cyc(0, 0, 4'b0100, 0, 0, 2'd0, 32'h0);
    cyc(0, 0, 4'b0100, 0, 0, 2'd0, 32'h0);
    cyc(0, 0, 4'b0100, 1, 1, 2'd0, 32'h0000_0401);
    rd("R9 cleared after set", 2'd0, 32'h0);
    cyc(0, 0, 4'b0000, 0, 0, 2'd0, 32'h0);
    cyc(0, 0, 4'b0100, 0, 0, 2'd0, 32'h0);
    cyc(0, 0, 4'b0100, 0, 0, 2'd0, 32'h0);
    cyc(0, 0, 4'b0100, 1, 1, 2'd0, 32'h0000_0400);
    rd("R9 pin edge wins", 2'd0, 32'h0000_0400);

    // random phase against the model (R1 R3 R4 R6 R7 R8 R9)
    for (int i = 0; i < 4000; i++) begin
      logic [NW-1:0] w;
      logic [1:0] a;
      w  = pins ^ NW'($urandom & $urandom & $urandom);
      a  = 2'($urandom);
      rv = (a == 2'd2) ? $urandom : ($urandom | $urandom);
      cyc(($urandom % 8) == 0, ($urandom % 8) == 0, w, ($urandom % 3) == 0,
          1'b1, a, rv);
      chk("R8 random irq", {31'b0, irq}, {31'b0, m_irq});
      a = 2'($urandom);
      rd("R6 random read", a, exp_read(a));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule